// File: doc/BRIEF.md
# Paired General Register Bank

This block holds six byte-wide general registers and a 16-bit stack pointer for a small 8-bit datapath. The bytes can be written and read one at a time. Adjacent bytes also form three 16-bit pairs. In a single clock the block can load a pair or the stack pointer with an immediate word, step it up or down by one, add it into the HL pair, swap HL with DE, copy HL into the stack pointer, or present HL as a jump target for the program counter.

A carry input and output connect the block to an external flag register. Only the 16-bit add into HL asks that register to take a new carry. All other 16-bit operations leave the flags alone.

The operation path is built around an enumerated operation code held in a `unique case`. There are eight named operations, and each completes in one clock:
- `OP_NOP`: idle.
- `OP_LOAD`: load an immediate word.
- `OP_INC`: increment.
- `OP_DEC`: decrement.
- `OP_ADDHL`: add a word into HL.
- `OP_XCHG`: swap HL and DE.
- `OP_HL2SP`: copy HL into the stack pointer.
- `OP_HL2PC`: issue HL as a jump target.

There is no multi-cycle sequencing. Every transition goes from the edge that accepts an operation to the result that is visible after that edge.

Top module: `regpair_file`

## Requirements
- R1: While `rst_n` is low, all six byte registers and the stack pointer are cleared to zero, and `carry_we` and `pc_load` are low.
- R2: A byte write with `wr8_en` high stores `wr8_data` at the next edge into the register picked by `wr8_sel`: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L. A write with select 6 or 7 changes no register. `rd8_data` returns the selected register combinationally, and returns 0 for select 6 or 7.
- R3: The pair/target codes on `op_tgt` are 0=BC, 1=DE, 2=HL, 3=SP. In each pair the first-named register is bits 15:8.
- R4: `OP_LOAD` (code 1) writes `op_imm` into the target pair or the stack pointer in one clock.
- R5: `OP_INC` (code 2) and `OP_DEC` (code 3) add or subtract one from the target modulo 65536, so 0xFFFF+1 gives 0x0000 and 0x0000-1 gives 0xFFFF. Neither raises `carry_we`.
- R6: `OP_ADDHL` (code 4) replaces HL with HL plus the target, which may be HL itself. The cycle after the operation, `carry_out` holds bit 16 of the sum and `carry_we` is high for exactly that cycle. `carry_in` does not enter the sum.
- R7: `OP_XCHG` (code 5) swaps the full contents of HL and DE in one clock.
- R8: `OP_HL2SP` (code 6) copies HL into the stack pointer and leaves HL unchanged.
- R9: `OP_HL2PC` (code 7) raises `pc_load` for one cycle after the edge, with `pc_target` equal to HL. No register changes.
- R10: When a byte write and a 16-bit operation target the same byte in one clock, the 16-bit result is stored. A byte write to a byte that the operation does not touch still takes effect.
- R11: In any cycle after an operation other than `OP_ADDHL`, `carry_out` repeats the `carry_in` sampled at that edge and `carry_we` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr8_en | input | 1 | Byte write strobe |
| wr8_sel | input | 3 | Byte write select (0..5 = B,C,D,E,H,L) |
| wr8_data | input | 8 | Byte write data |
| rd8_sel | input | 3 | Byte read select |
| rd8_data | output | 8 | Byte read data, combinational |
| op_valid | input | 1 | 16-bit operation strobe |
| op_code | input | 3 | 16-bit operation code |
| op_tgt | input | 2 | Pair or stack pointer target |
| op_imm | input | 16 | Immediate word for load |
| carry_in | input | 1 | Current carry flag from the flag register |
| carry_out | output | 1 | Carry value for the flag register |
| carry_we | output | 1 | Flag register carry update strobe |
| pc_load | output | 1 | Jump strobe to the program counter |
| pc_target | output | 16 | Jump target word |
| sp_out | output | 16 | Current stack pointer |

## Verification
A corrupted byte, or a pair that is wired high and low the wrong way round, shows at `rd8_data` as soon as that byte is selected after the faulty edge. A stack pointer error shows on `sp_out` in the very next cycle. A carry computed from the wrong source, or a flag strobe on a step operation, appears on `carry_out`/`carry_we` in the one cycle after the operation, and is gone one cycle later. Stale or wrong HL content leaks out through the next add, swap, stack-pointer copy or jump, each one clock after that operation is issued.

// File: rtl/regpair_pkg.sv
package regpair_pkg;
    localparam int NUM_BYTES = 6;
    localparam int NUM_PAIRS = 3;
    localparam int SEL_W     = 3;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_INC   = 3'd2,
        OP_DEC   = 3'd3,
        OP_ADDHL = 3'd4,
        OP_XCHG  = 3'd5,
        OP_HL2SP = 3'd6,
        OP_HL2PC = 3'd7
    } pair_op_e;

    typedef enum logic [1:0] {
        PT_BC = 2'd0,
        PT_DE = 2'd1,
        PT_HL = 2'd2,
        PT_SP = 2'd3
    } pair_tgt_e;
endpackage

// File: rtl/pair_alu.sv
module pair_alu
    import regpair_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              op_valid,
    input  pair_op_e          op,
    input  pair_tgt_e         tgt,
    input  logic [WORD_W-1:0] imm,
    input  logic [WORD_W-1:0] bc,
    input  logic [WORD_W-1:0] de,
    input  logic [WORD_W-1:0] hl,
    input  logic [WORD_W-1:0] sp,
    output logic [NUM_PAIRS-1:0]              pair_we,
    output logic [NUM_PAIRS-1:0][WORD_W-1:0]  pair_nx,
    output logic              sp_we,
    output logic [WORD_W-1:0] sp_nx,
    output logic              add_fire,
    output logic              add_carry,
    output logic              jump_fire
);
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] res;
    logic              res_we;
    logic [WORD_W:0]   sum;

    always_comb begin
        unique case (tgt)
            PT_BC: src = bc;
            PT_DE: src = de;
            PT_HL: src = hl;
            PT_SP: src = sp;
        endcase
    end

    assign sum = {1'b0, hl} + {1'b0, src};

    always_comb begin
        res       = src;
        res_we    = 1'b0;
        pair_we   = '0;
        pair_nx[0] = bc;
        pair_nx[1] = de;
        pair_nx[2] = hl;
        sp_we     = 1'b0;
        sp_nx     = sp;
        add_fire  = 1'b0;
        add_carry = 1'b0;
        jump_fire = 1'b0;
        if (op_valid) begin
            unique case (op)
                OP_NOP: ;
                OP_LOAD: begin
                    res    = imm;
                    res_we = 1'b1;
                end
                OP_INC: begin
                    res    = src + 1'b1;
                    res_we = 1'b1;
                end
                OP_DEC: begin
                    res    = src - 1'b1;
                    res_we = 1'b1;
                end
                OP_ADDHL: begin
                    pair_nx[2] = sum[WORD_W-1:0];
                    pair_we[2] = 1'b1;
                    add_fire   = 1'b1;
                    add_carry  = sum[WORD_W];
                end
                OP_XCHG: begin
                    pair_nx[1] = hl;
                    pair_nx[2] = de;
                    pair_we[1] = 1'b1;
                    pair_we[2] = 1'b1;
                end
                OP_HL2SP: begin
                    sp_nx = hl;
                    sp_we = 1'b1;
                end
                OP_HL2PC: jump_fire = 1'b1;
            endcase
            if (res_we) begin
                unique case (tgt)
                    PT_BC: begin pair_nx[0] = res; pair_we[0] = 1'b1; end
                    PT_DE: begin pair_nx[1] = res; pair_we[1] = 1'b1; end
                    PT_HL: begin pair_nx[2] = res; pair_we[2] = 1'b1; end
                    PT_SP: begin sp_nx = res;      sp_we = 1'b1;      end
                endcase
            end
        end
    end
endmodule

// File: rtl/regpair_bank.sv
module regpair_bank
    import regpair_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr8_en,
    input  logic [SEL_W-1:0]                  wr8_sel,
    input  logic [BYTE_W-1:0]                 wr8_data,
    input  logic [NUM_PAIRS-1:0]              pair_we,
    input  logic [NUM_PAIRS-1:0][WORD_W-1:0]  pair_nx,
    output logic [NUM_BYTES-1:0][BYTE_W-1:0]  bytes_q
);
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        localparam int PIDX = i / 2;
        localparam bit HIGH = (i % 2) == 0;
        logic [BYTE_W-1:0] op_byte;

        if (HIGH) begin : g_hi
            assign op_byte = pair_nx[PIDX][WORD_W-1:BYTE_W];
        end else begin : g_lo
            assign op_byte = pair_nx[PIDX][BYTE_W-1:0];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bytes_q[i] <= '0;
            end else if (pair_we[PIDX]) begin
                bytes_q[i] <= op_byte;
            end else if (wr8_en && wr8_sel == SEL_W'(i)) begin
                bytes_q[i] <= wr8_data;
            end
        end
    end
endmodule

// File: rtl/regpair_file.sv
module regpair_file
    import regpair_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr8_en,
    input  logic [2:0]        wr8_sel,
    input  logic [BYTE_W-1:0] wr8_data,
    input  logic [2:0]        rd8_sel,
    output logic [BYTE_W-1:0] rd8_data,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [1:0]        op_tgt,
    input  logic [WORD_W-1:0] op_imm,
    input  logic              carry_in,
    output logic              carry_out,
    output logic              carry_we,
    output logic              pc_load,
    output logic [WORD_W-1:0] pc_target,
    output logic [WORD_W-1:0] sp_out
);
    logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes_q;
    logic [NUM_PAIRS-1:0]             pair_we;
    logic [NUM_PAIRS-1:0][WORD_W-1:0] pair_nx;
    logic [WORD_W-1:0] bc_cur, de_cur, hl_cur;
    logic [WORD_W-1:0] sp_q, sp_nx;
    logic              sp_we, add_fire, add_carry, jump_fire;
    pair_op_e          op_e;
    pair_tgt_e         tgt_e;

    assign op_e   = pair_op_e'(op_code);
    assign tgt_e  = pair_tgt_e'(op_tgt);
    assign bc_cur = {bytes_q[0], bytes_q[1]};
    assign de_cur = {bytes_q[2], bytes_q[3]};
    assign hl_cur = {bytes_q[4], bytes_q[5]};

    pair_alu #(.BYTE_W(BYTE_W)) u_alu (
        .op_valid (op_valid),
        .op       (op_e),
        .tgt      (tgt_e),
        .imm      (op_imm),
        .bc       (bc_cur),
        .de       (de_cur),
        .hl       (hl_cur),
        .sp       (sp_q),
        .pair_we  (pair_we),
        .pair_nx  (pair_nx),
        .sp_we    (sp_we),
        .sp_nx    (sp_nx),
        .add_fire (add_fire),
        .add_carry(add_carry),
        .jump_fire(jump_fire)
    );

    regpair_bank #(.BYTE_W(BYTE_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr8_en  (wr8_en),
        .wr8_sel (wr8_sel),
        .wr8_data(wr8_data),
        .pair_we (pair_we),
        .pair_nx (pair_nx),
        .bytes_q (bytes_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (sp_we) begin
            sp_q <= sp_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_out <= 1'b0;
            carry_we  <= 1'b0;
            pc_load   <= 1'b0;
            pc_target <= '0;
        end else begin
            carry_out <= add_fire ? add_carry : carry_in;
            carry_we  <= add_fire;
            pc_load   <= jump_fire;
            if (jump_fire) begin
                pc_target <= hl_cur;
            end
        end
    end

    always_comb begin
        if (rd8_sel < 3'(NUM_BYTES)) begin
            rd8_data = bytes_q[rd8_sel];
        end else begin
            rd8_data = '0;
        end
    end

    assign sp_out = sp_q;
endmodule

// File: rtl/regpair_file_chk.sv
module regpair_file_chk
    import regpair_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic [1:0]        op_tgt,
    input logic              carry_we,
    input logic              pc_load,
    input logic [WORD_W-1:0] pc_target,
    input logic [WORD_W-1:0] sp_out,
    input logic [WORD_W-1:0] de_cur,
    input logic [WORD_W-1:0] hl_cur
);
    a_r5_sp_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_INC && op_tgt == PT_SP)
        |=> sp_out == $past(sp_out) + 1'b1);

    a_r5_sp_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_DEC && op_tgt == PT_SP)
        |=> sp_out == $past(sp_out) - 1'b1);

    a_r6_flag_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        carry_we |-> $past(op_valid && op_code == OP_ADDHL));

    a_r6_add_raises_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ADDHL) |=> carry_we);

    a_r7_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_XCHG)
        |=> (hl_cur == $past(de_cur)) && (de_cur == $past(hl_cur)));

    a_r8_hl_to_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_HL2SP)
        |=> (sp_out == $past(hl_cur)) && $stable(hl_cur));

    a_r9_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_HL2PC)
        |=> pc_load && (pc_target == $past(hl_cur)));

    a_r9_jump_source: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> $past(op_valid && op_code == OP_HL2PC));
endmodule

bind regpair_file regpair_file_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_tgt   (op_tgt),
    .carry_we (carry_we),
    .pc_load  (pc_load),
    .pc_target(pc_target),
    .sp_out   (sp_out),
    .de_cur   (de_cur),
    .hl_cur   (hl_cur)
);

// File: tb/regpair_file_test.sv
`timescale 1ns/1ps
module regpair_file_test;
    import regpair_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr8_en = 1'b0;
    logic [2:0]  wr8_sel = '0;
    logic [7:0]  wr8_data = '0;
    logic [2:0]  rd8_sel = '0;
    logic [7:0]  rd8_data;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [1:0]  op_tgt = '0;
    logic [15:0] op_imm = '0;
    logic        carry_in = 1'b0;
    logic        carry_out, carry_we, pc_load;
    logic [15:0] pc_target, sp_out;

    always #4 clk = ~clk;

    regpair_file uut (.*);

    typedef struct {
        string       req;
        int          kind;
        int          sel;
        logic [15:0] exp;
    } item_t;

    item_t sbq[$];
    int nchk = 0;
    int nfail = 0;
    logic [7:0]  m[6];
    logic [15:0] msp;

    function automatic logic [15:0] mget(int t);
        case (t)
            0: return {m[0], m[1]};
            1: return {m[2], m[3]};
            2: return {m[4], m[5]};
            default: return msp;
        endcase
    endfunction

    task automatic mset(int t, logic [15:0] v);
        if (t == 3) msp = v;
        else begin
            m[2*t]   = v[15:8];
            m[2*t+1] = v[7:0];
        end
    endtask

    task automatic push(string r, int k, int s, logic [15:0] e);
        item_t it;
        it.req = r; it.kind = k; it.sel = s; it.exp = e;
        sbq.push_back(it);
    endtask

    task automatic push_state(string r);
        for (int i = 0; i < 6; i++) push(r, 0, i, {8'h00, m[i]});
        push(r, 1, 0, msp);
    endtask

    // monitor: pops scoreboard items and compares them with the ports
    task automatic monitor_drain();
        item_t it;
        logic [15:0] act;
        while (sbq.size() > 0) begin
            it = sbq.pop_front();
            case (it.kind)
                0: begin rd8_sel = 3'(it.sel); #1; act = {8'h00, rd8_data}; end
                1: act = sp_out;
                2: act = {15'd0, carry_out};
                3: act = {15'd0, carry_we};
                4: act = {15'd0, pc_load};
                default: act = pc_target;
            endcase
            nchk++;
            if (act !== it.exp) begin
                nfail++;
                $display("FAIL %s kind=%0d sel=%0d actual=%h expected=%h",
                         it.req, it.kind, it.sel, act, it.exp);
            end
        end
    endtask

    task automatic clock_once();
        @(posedge clk);
        @(negedge clk);
        wr8_en = 1'b0;
        op_valid = 1'b0;
    endtask

    task automatic write8(int s, logic [7:0] d, string r);
        wr8_en = 1'b1; wr8_sel = 3'(s); wr8_data = d;
        clock_once();
        if (s < 6) m[s] = d;
        push_state(r);
        if (s >= 6) push(r, 0, s, 16'h0000);
        monitor_drain();
    endtask

    // driver: optional byte write alongside a 16-bit operation
    task automatic drive_op(pair_op_e c, int t, logic [15:0] imm,
                            bit w8, int ws, logic [7:0] wd, string r);
        logic [15:0] src, hl, de, res;
        logic [16:0] sum;
        bit          res_we;
        src = mget(t); hl = mget(2); de = mget(1);
        sum = {1'b0, hl} + {1'b0, src};
        res = src; res_we = 1'b0;
        op_valid = 1'b1; op_code = c; op_tgt = 2'(t); op_imm = imm;
        if (w8) begin wr8_en = 1'b1; wr8_sel = 3'(ws); wr8_data = wd; end
        clock_once();
        push(r, 3, 0, {15'd0, c == OP_ADDHL});
        push(r, 2, 0, {15'd0, (c == OP_ADDHL) ? sum[16] : carry_in});
        push(r, 4, 0, {15'd0, c == OP_HL2PC});
        if (c == OP_HL2PC) push(r, 5, 0, hl);
        if (w8 && ws < 6) m[ws] = wd;
        case (c)
            OP_LOAD:  begin res = imm;      res_we = 1'b1; end
            OP_INC:   begin res = src + 1;  res_we = 1'b1; end
            OP_DEC:   begin res = src - 1;  res_we = 1'b1; end
            OP_ADDHL: mset(2, sum[15:0]);
            OP_XCHG:  begin mset(2, de); mset(1, hl); end
            OP_HL2SP: msp = hl;
            default: ;
        endcase
        if (res_we) mset(t, res);
        push_state(r);
        monitor_drain();
    endtask

    task automatic do_op(pair_op_e c, int t, logic [15:0] imm, string r);
        drive_op(c, t, imm, 1'b0, 0, 8'h00, r);
    endtask

    initial begin
        #(8 * 100000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) m[i] = 8'h00;
        msp = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        push("R1", 3, 0, 16'h0); push("R1", 4, 0, 16'h0);
        push_state("R1");
        monitor_drain();
        rst_n = 1'b1;
        @(negedge clk);

        // R2: byte writes and reads
        write8(0, 8'h11, "R2"); write8(1, 8'h22, "R2");
        write8(2, 8'h33, "R2"); write8(3, 8'h44, "R2");
        write8(4, 8'h55, "R2"); write8(5, 8'h66, "R2");
        write8(6, 8'hAA, "R2"); write8(7, 8'hBB, "R2");

        // R3 / R4: pair layout and immediate load
        do_op(OP_LOAD, 0, 16'h1234, "R3_R4");
        do_op(OP_LOAD, 2, 16'hBEEF, "R3_R4");
        do_op(OP_LOAD, 3, 16'hFFFF, "R4");

        // R5: wrapping steps, no flag strobe
        do_op(OP_INC, 3, 16'h0, "R5");
        do_op(OP_DEC, 3, 16'h0, "R5");
        do_op(OP_LOAD, 1, 16'h0000, "R5");
        do_op(OP_DEC, 1, 16'h0, "R5");
        do_op(OP_INC, 1, 16'h0, "R5");
        do_op(OP_INC, 0, 16'h0, "R5");

        // R6: add into HL with carry
        do_op(OP_LOAD, 2, 16'h8001, "R6");
        do_op(OP_LOAD, 0, 16'h8000, "R6");
        do_op(OP_ADDHL, 0, 16'h0, "R6");
        do_op(OP_LOAD, 2, 16'h4000, "R6");
        do_op(OP_ADDHL, 2, 16'h0, "R6");
        do_op(OP_ADDHL, 2, 16'h0, "R6");
        do_op(OP_ADDHL, 3, 16'h0, "R6");
        do_op(OP_LOAD, 1, 16'h0F0F, "R6");
        do_op(OP_ADDHL, 1, 16'h0, "R6");

        // R7: swap
        do_op(OP_LOAD, 1, 16'hABCD, "R7");
        do_op(OP_LOAD, 2, 16'h1357, "R7");
        do_op(OP_XCHG, 0, 16'h0, "R7");

        // R8 / R9: stack pointer copy and jump
        do_op(OP_HL2SP, 0, 16'h0, "R8");
        do_op(OP_HL2PC, 0, 16'h0, "R9");

        // R10: same-cycle byte write conflicts
        drive_op(OP_INC, 2, 16'h0, 1'b1, 5, 8'h77, "R10");
        drive_op(OP_LOAD, 0, 16'h0102, 1'b1, 4, 8'h99, "R10");
        drive_op(OP_XCHG, 0, 16'h0, 1'b1, 2, 8'h5A, "R10");

        // R11: carry pass-through on non-add cycles, carry_in kept out of the sum
        carry_in = 1'b1;
        do_op(OP_NOP, 0, 16'h0, "R11");
        do_op(OP_INC, 0, 16'h0, "R11");
        do_op(OP_LOAD, 2, 16'h0001, "R11");
        do_op(OP_LOAD, 0, 16'h0001, "R11");
        do_op(OP_ADDHL, 0, 16'h0, "R11");
        carry_in = 1'b0;
        do_op(OP_NOP, 0, 16'h0, "R11");

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule